// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers asynchronous serial characters from a single input line and queues them for a host. A clock enable, pulsed at sixteen times the bit rate, sets the pace of the receiver. The input first passes through a synchronizer. A falling edge seen while the line was idle starts a count. At the middle of the start bit the line is sampled again. If it has gone high, the edge is treated as noise and dropped. Otherwise the data bits and the stop bit are each sampled at their centres. The finished character goes into a first-in first-out queue together with its framing and break flags.

The host takes characters one at a time with a read strobe. The head of the queue, and the error flags that belong to that character, sit on the output ports. A small line status vector reports whether data is waiting, whether a character was lost to a full queue, and the flags of the head character. A separate strobe clears the sticky lost-character flag.

Top module: `uartrx_top`

## Requirements
- R1: A falling edge is recognised only after the line was seen high on an earlier tick. The start bit is then sampled OSR/2 ticks after the tick that first saw it low. A low sample there accepts the start bit.
- R2: If the line is high at that start-centre sample, the receiver goes back to idle and nothing enters the queue, so a low glitch shorter than half a bit produces no character.
- R3: After an accepted start bit, the DATA_BITS data bits are sampled every OSR ticks at their centres, least significant bit first. The character is queued when the stop bit is sampled, OSR ticks after the last data bit.
- R4: A low stop-bit sample marks the character with a framing error. `line_stat[3]` shows that mark while the character is at the head of the queue.
- R5: A character whose data bits are all zero and whose stop bit is low is marked as a break on `line_stat[4]`. A line held low then yields only one character, because a new start needs the line to be high first.
- R6: The queue holds up to DEPTH characters (default 128) and returns them in arrival order.
- R7: A `rd_strobe` cycle while the queue holds data removes the head character. A `rd_strobe` on an empty queue changes nothing, and later characters still arrive intact.
- R8: `data_ready`, which is also `line_stat[0]`, is high exactly while the queue holds at least one character.
- R9: A character that completes while the queue is full is discarded and sets `line_stat[1]`. That flag stays set through reads of data and clears only on an `lsr_rd` cycle.
- R10: After reset the queue is empty and all of `line_stat` is 0. Bit 2 (parity) always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle enable at 16x the bit rate (OSR x bit rate) |
| ser_in | input | 1 | Asynchronous serial input, idle high |
| rd_strobe | input | 1 | Take the head character from the queue |
| lsr_rd | input | 1 | Clear the sticky overrun flag |
| rd_data | output | DATA_BITS | Head character, valid while data_ready is high |
| data_ready | output | 1 | Queue not empty |
| line_stat | output | 5 | {break, framing, parity(0), overrun, ready} |

## Verification
The bench keeps OSR at 16 and DATA_BITS at 8. It shrinks DEPTH to 4, so that a fifth character arrives while the queue is full and the overrun path, with its sticky flag and discarded byte, can be reached in a few frames. It drives `os_tick` every fourth clock, so each bit lasts 64 cycles and there are several clocks between samples. Short low pulses on either side of the start-centre sample separate a rejected glitch from an accepted start.

// File: rtl/uartrx_pkg.sv
package uartrx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // Positions inside the line status vector
  localparam int LS_READY   = 0;
  localparam int LS_OVERRUN = 1;
  localparam int LS_PARITY  = 2;
  localparam int LS_FRAME   = 3;
  localparam int LS_BREAK   = 4;
  localparam int LS_WIDTH   = 5;

endpackage

// File: rtl/uartrx_sync.sv
module uartrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/uartrx_framer.sv
module uartrx_framer
  import uartrx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 rx,
  output logic                 push,
  output logic [DATA_BITS-1:0] push_data,
  output logic                 push_fe,
  output logic                 push_brk
);

  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int HALF  = OSR / 2;

  rx_state_e            state;
  logic [CNT_W-1:0]     cnt;
  logic [BIT_W-1:0]     bitn;
  logic [DATA_BITS-1:0] shreg;
  logic                 line_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      line_hi   <= 1'b0;
      push      <= 1'b0;
      push_data <= '0;
      push_fe   <= 1'b0;
      push_brk  <= 1'b0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: begin
            line_hi <= rx;
            if (!rx && line_hi) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == CNT_W'(HALF - 1)) begin
              cnt <= '0;
              if (rx) begin
                state   <= RX_IDLE;
                line_hi <= 1'b1;
              end else begin
                state <= RX_DATA;
                bitn  <= '0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == CNT_W'(OSR - 1)) begin
              cnt   <= '0;
              shreg <= {rx, shreg[DATA_BITS-1:1]};
              if (bitn == BIT_W'(DATA_BITS - 1)) state <= RX_STOP;
              else                               bitn  <= bitn + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == CNT_W'(OSR - 1)) begin
              cnt       <= '0;
              push      <= 1'b1;
              push_data <= shreg;
              push_fe   <= !rx;
              push_brk  <= !rx && (shreg == '0);
              line_hi   <= rx;
              state     <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  AST_START_REJECT: assert property (@(posedge clk) disable iff (rst)
    (state == RX_START && tick && cnt == CNT_W'(HALF - 1) && rx) |=> (state == RX_IDLE && !push)); // R2
  AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (rst)
    push |=> !push); // R3
  AST_PUSH_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
    push |-> $past(state) == RX_STOP); // R3
  AST_BREAK_IMPLIES_FE: assert property (@(posedge clk) disable iff (rst)
    push && push_brk |-> push_fe); // R5

endmodule

// File: rtl/uartrx_fifo.sv
module uartrx_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  output logic [WIDTH-1:0] rdata,
  output logic             ready,
  output logic             drop
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp, rp_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             psh, pop;
  logic [WIDTH-1:0] mem_q, byp_q;
  logic             byp_sel;

  assign pop     = rd && (cnt != '0);
  assign psh     = wr && (cnt != CNT_W'(DEPTH));
  assign drop    = wr && !psh;
  assign rp_nxt  = rp + PTR_W'(pop);
  assign cnt_nxt = cnt + CNT_W'(psh) - CNT_W'(pop);

  always_ff @(posedge clk) begin
    if (psh) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    mem_q   <= mem[rp_nxt];
    byp_q   <= wdata;
    byp_sel <= psh && (wp == rp_nxt);
  end

  assign rdata = byp_sel ? byp_q : mem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      ready <= 1'b0;
    end else begin
      if (psh) wp <= wp + 1'b1;
      rp    <= rp_nxt;
      cnt   <= cnt_nxt;
      ready <= (cnt_nxt != '0);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH)); // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (rd && cnt == '0 && !wr) |=> (!ready && rp == $past(rp))); // R7
  AST_READY_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ready == (cnt != '0)); // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (drop && !rd) |=> $stable(cnt)); // R9

endmodule

// File: rtl/uartrx_top.sv
module uartrx_top
  import uartrx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DATA_BITS   = 8,
  parameter int DEPTH       = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 os_tick,
  input  logic                 ser_in,
  input  logic                 rd_strobe,
  input  logic                 lsr_rd,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 data_ready,
  output logic [4:0]           line_stat
);

  localparam int ENTRY_W = DATA_BITS + 2;

  logic                 rx_s;
  logic                 push, push_fe, push_brk;
  logic [DATA_BITS-1:0] push_data;
  logic [ENTRY_W-1:0]   head;
  logic                 drop;
  logic                 ovr;

  uartrx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  (ser_in),
    .dout (rx_s)
  );

  uartrx_framer #(.OSR(OSR), .DATA_BITS(DATA_BITS)) framer_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (os_tick),
    .rx        (rx_s),
    .push      (push),
    .push_data (push_data),
    .push_fe   (push_fe),
    .push_brk  (push_brk)
  );

  uartrx_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) fifo_i (
    .clk   (clk),
    .rst   (rst),
    .wr    (push),
    .wdata ({push_brk, push_fe, push_data}),
    .rd    (rd_strobe),
    .rdata (head),
    .ready (data_ready),
    .drop  (drop)
  );

  always_ff @(posedge clk) begin
    if (rst)         ovr <= 1'b0;
    else if (drop)   ovr <= 1'b1;
    else if (lsr_rd) ovr <= 1'b0;
  end

  assign rd_data               = head[DATA_BITS-1:0];
  assign line_stat[LS_READY]   = data_ready;
  assign line_stat[LS_OVERRUN] = ovr;
  assign line_stat[LS_PARITY]  = 1'b0;
  assign line_stat[LS_FRAME]   = data_ready && head[DATA_BITS];
  assign line_stat[LS_BREAK]   = data_ready && head[DATA_BITS+1];

  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ovr && !lsr_rd) |=> ovr); // R9
  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovr); // R9

endmodule

// File: tb/uartrx_top_tb_top.sv
module uartrx_top_tb_top;

  localparam int OSR      = 16;
  localparam int DBITS    = 8;
  localparam int DEPTH    = 4;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = OSR * TICK_DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic os_tick = 1'b0;
  logic ser_in = 1'b1;
  logic rd_strobe = 1'b0;
  logic lsr_rd = 1'b0;
  logic [DBITS-1:0] rd_data;
  logic data_ready;
  logic [4:0] line_stat;

  int checks = 0;
  int errors = 0;
  int tdiv = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    os_tick <= (tdiv == TICK_DIV - 1);
  end

  uartrx_top #(.OSR(OSR), .DATA_BITS(DBITS), .DEPTH(DEPTH), .SYNC_STAGES(2)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .os_tick    (os_tick),
    .ser_in     (ser_in),
    .rd_strobe  (rd_strobe),
    .lsr_rd     (lsr_rd),
    .rd_data    (rd_data),
    .data_ready (data_ready),
    .line_stat  (line_stat)
  );

  // {data, stop bit level}
  localparam logic [8:0] VEC [6] = '{
    {8'h55, 1'b1}, {8'hA3, 1'b1}, {8'h00, 1'b1},
    {8'hFF, 1'b1}, {8'h3C, 1'b0}, {8'h00, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stopb);
    ser_in = 1'b0;
    hold(BIT_CLK);
    for (int i = 0; i < DBITS; i++) begin
      ser_in = b[i];
      hold(BIT_CLK);
    end
    ser_in = stopb;
    hold(BIT_CLK);
    ser_in = 1'b1;
    hold(2 * BIT_CLK);
  endtask

  task automatic pop();
    rd_strobe = 1'b1;
    hold(1);
    rd_strobe = 1'b0;
    hold(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    hold(5);
    rst = 1'b0;
    hold(2);
    // R10 reset state
    chk("R10 line_stat after reset", 32'(line_stat), 0);
    chk("R8 ready after reset", 32'(data_ready), 0);
    hold(2 * BIT_CLK);

    // Table-driven frames: R3, R4, R5, R7, R8
    for (int k = 0; k < 6; k++) begin
      logic [7:0] d;
      logic sb;
      d  = VEC[k][8:1];
      sb = VEC[k][0];
      send(d, sb);
      chk("R8 ready after frame", 32'(data_ready), 1);
      chk("R3 data value", 32'(rd_data), 32'(d));
      chk("R4 framing flag", 32'(line_stat[3]), 32'(!sb));
      chk("R5 break flag", 32'(line_stat[4]), 32'(!sb && d == 8'h00));
      chk("R10 parity bit zero", 32'(line_stat[2]), 0);
      pop();
      chk("R7 ready after pop", 32'(data_ready), 0);
      chk("R4 framing clear when empty", 32'(line_stat[3]), 0);
    end

    // R2 short glitch is dropped
    ser_in = 1'b0;
    hold(5 * TICK_DIV);
    ser_in = 1'b1;
    hold(12 * BIT_CLK);
    chk("R2 no char from glitch", 32'(data_ready), 0);

    // R1 low longer than half a bit is accepted at the centre -> 0xFF
    ser_in = 1'b0;
    hold(12 * TICK_DIV);
    ser_in = 1'b1;
    hold(12 * BIT_CLK);
    chk("R1 start accepted", 32'(data_ready), 1);
    chk("R1 data all ones", 32'(rd_data), 32'hFF);
    chk("R1 no framing error", 32'(line_stat[3]), 0);
    pop();

    // R7 read on empty queue is ignored
    pop();
    chk("R7 empty read ignored", 32'(data_ready), 0);
    send(8'h81, 1'b1);
    chk("R7 next char intact", 32'(rd_data), 32'h81);
    pop();

    // R5 line held low gives one character only
    ser_in = 1'b0;
    hold(30 * BIT_CLK);
    ser_in = 1'b1;
    hold(2 * BIT_CLK);
    chk("R5 break char present", 32'(data_ready), 1);
    chk("R5 break data zero", 32'(rd_data), 0);
    chk("R5 break flag", 32'(line_stat[4]), 1);
    pop();
    chk("R5 only one char", 32'(data_ready), 0);

    // R6/R9 fill queue and overrun
    for (int k = 0; k < DEPTH + 1; k++) send(8'(8'h11 + k), 1'b1);
    chk("R9 overrun set", 32'(line_stat[1]), 1);
    for (int k = 0; k < DEPTH; k++) begin
      chk("R8 ready while data", 32'(data_ready), 1);
      chk("R6 order", 32'(rd_data), 32'(8'h11 + k));
      pop();
    end
    chk("R9 extra char discarded", 32'(data_ready), 0);
    chk("R9 overrun sticky after reads", 32'(line_stat[1]), 1);
    lsr_rd = 1'b1;
    hold(1);
    lsr_rd = 1'b0;
    hold(1);
    chk("R9 overrun cleared", 32'(line_stat[1]), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule